// File: doc/BRIEF.md
# Super I/O Configuration Register File

This block is the configuration unit of a legacy PC Super I/O device. A host reaches it through a two-byte index/data window on an 8-bit I/O bus. To select a register, the host writes an index to the even address of the window. It then reads or writes that register through the odd address.

The unit holds a sparse set of 8-bit registers, and each register applies its own write mask. From the register contents it decodes configuration for five sub-devices:

- the floppy controller: enable and base port;
- the parallel port: enable, base port and IRQ;
- two serial ports: base port, IRQ and clock select;
- the secondary IDE channel: enable, command base and control port.

It also produces one-cycle reset pulses and one-cycle change strobes for the sub-devices. The sub-devices themselves are outside the block.

Straps select where the window sits in the I/O space, supply the identification byte held in register 0x02, and say whether an IDE channel is fitted. The external reset is asserted asynchronously. Its release passes through a two-stage synchroniser, so the core leaves reset two clocks after `rst_n` rises. Register 0x02 takes the strap value on the first clock after that.

Top module: `sio_cfg_regfile`

## Requirements
- R1: The window sits at `strap_win_sel` 0 = 0x022, 1 = 0x024, 2 = 0x26E, 3 = 0x398. A write with `io_addr` equal to the base loads the index register. A write to base+1 writes the register that the index selects. Writes to any other address change nothing.
- R2: Reads are combinational while `io_rd` is high.
  - A read at the base returns the index.
  - A read at base+1 returns the selected register when the index is below 0x51. Unimplemented indices below 0x51 read 0x00.
  - A read at base+1 returns 0xFF when the index is 0x51 or above.
  - When `io_rd` is low or the address is outside the window, `io_rdata` is 0xFF.
- R3: Write masks are: 0x03 keeps 0xF8, 0x10 keeps 0x83, 0x11 keeps 0x0F, 0x20 keeps 0xEF, 0x21 keeps 0x2F, 0x30 and 0x40 keep 0x9F, 0x31 and 0x41 keep 0x1F, and 0x50 keeps 0x07. Writes to any other index are ignored, including 0x00.
- R4: After reset, register 0x02 holds `strap_id`. A later write to 0x02 stores the written bit 0, keeps bits 6:3, and clears bits 7, 2 and 1.
- R5: Reset values: 0x00 reads 0xA0 at all times; 0x10 = 0x01; 0x31 = 0x41 = 0x02; 0x50 = 0x01. Every other register resets to 0x00.
- R6: Floppy: `fdc_en` is register 0x10 bit 0. `fdc_base` is 0x370 when bit 1 is set and 0x3F0 when it is clear.
- R7: Parallel port:
  - Register 0x20 bits 2:1 select the base: 0 = 0x378, 1 = 0x278, 2 = 0x3BC, 3 = 0x000.
  - `lpt_en` is bit 0 ANDed with the select not being 3.
  - `lpt_irq` is 7 when bit 3 is set and 5 when it is clear.
- R8: Serial port n uses register 0x30+0x10·n; its fields are at slice [16n+:16] of `uart_base` and [4n+:4] of `uart_irq`.
  - Bits 3:1 select the base from 0x3F8, 0x2F8, 0x220, 0x228, 0x238, 0x2E8, 0x338, 0x3E8 (select 0 to 7).
  - Bit 4 gives IRQ 4 when set and IRQ 3 when clear.
  - `uart_clk_2m[n]` is bit 7 (1 = 2 MHz, 0 = 24/13 MHz).
- R9: A write to register 0x11 that takes bit 2 from 0 to 1 raises `fdc_reset_pulse` for exactly one cycle. The same rule on 0x31 and 0x41 raises bit n of `uart_reset_pulse`. A write that leaves bit 2 set raises no pulse.
- R10: IDE, when `strap_ide_present` is 1:
  - `ide_en` is register 0x50 bit 0.
  - Bit 1 selects command base 0x170 with control port 0x376 when set, and 0x1F0 with 0x3F6 when clear.
  - When the strap is 0, `ide_en`, both bases and `ide_cfg_change` are 0.
- R11: A change strobe is high for one cycle after a write alters that sub-device's decode bits:
  - `fdc_cfg_change`: 0x10 bits 1:0.
  - `lpt_cfg_change`: 0x20 bits 2:0.
  - `uart_cfg_change[n]`: bits 3:1 of that port's register.
  - `ide_cfg_change`: 0x50 bits 1:0.
  - A write that alters only other bits raises no strobe.
- R12: A register write takes effect on the clock edge where the data write is sampled. Decoded outputs, reset pulses and change strobes all change together in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_win_sel | input | 2 | Window base select strap |
| strap_id | input | 8 | Value loaded into register 0x02 after reset |
| strap_ide_present | input | 1 | IDE channel fitted |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| fdc_en | output | 1 | Floppy enable |
| fdc_base | output | 16 | Floppy base port |
| fdc_reset_pulse | output | 1 | Floppy reset pulse |
| fdc_cfg_change | output | 1 | Floppy configuration changed |
| lpt_en | output | 1 | Parallel port enable |
| lpt_base | output | 16 | Parallel base port |
| lpt_irq | output | 4 | Parallel IRQ number |
| lpt_cfg_change | output | 1 | Parallel configuration changed |
| uart_base | output | 32 | Serial base ports, 16 bits per port |
| uart_irq | output | 8 | Serial IRQ numbers, 4 bits per port |
| uart_clk_2m | output | 2 | Serial clock select per port |
| uart_reset_pulse | output | 2 | Serial reset pulse per port |
| uart_cfg_change | output | 2 | Serial configuration changed per port |
| ide_en | output | 1 | Secondary IDE enable |
| ide_cmd_base | output | 16 | IDE command block base |
| ide_ctl_base | output | 16 | IDE control port |
| ide_cfg_change | output | 1 | IDE configuration changed |

## Verification
The assertions check the following on every cycle:
- the index changes only on an index write and takes the written byte;
- reset pulses last one cycle and occur only on a 0-to-1 edge of the reset bit;
- a change strobe rises exactly when its decode bits differ from the previous cycle;
- writes to unlisted indices leave all state untouched;
- bits 6:3 of register 0x02 never move after the strap load;
- a parallel enable never comes with a null base, and the IDE outputs stay silent without the strap.

Only the bench's scenarios can show the rest:
- the exact masked value of each register;
- the legacy port and IRQ each field selects;
- the reset contents and strap loading;
- the window placement for each strap setting.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 16;
  localparam int PORT_W   = 16;
  localparam int IRQ_W    = 4;
  localparam int UART_CNT = 2;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [PORT_W-1:0] port_t;

  // register indices
  localparam byte_t IX_ID        = 8'h00;
  localparam byte_t IX_STRAP     = 8'h02;
  localparam byte_t IX_MISC      = 8'h03;
  localparam byte_t IX_FDC       = 8'h10;
  localparam byte_t IX_FDC_CTL   = 8'h11;
  localparam byte_t IX_LPT       = 8'h20;
  localparam byte_t IX_LPT_CTL   = 8'h21;
  localparam byte_t IX_UART_BASE = 8'h30;
  localparam byte_t IX_UART_STEP = 8'h10;
  localparam byte_t IX_CTL_OFS   = 8'h01;
  localparam byte_t IX_IDE       = 8'h50;
  localparam byte_t IX_LIMIT     = 8'h51;

  // write masks
  localparam byte_t MK_MISC       = 8'hF8;
  localparam byte_t MK_FDC        = 8'h83;
  localparam byte_t MK_FDC_CTL    = 8'h0F;
  localparam byte_t MK_LPT        = 8'hEF;
  localparam byte_t MK_LPT_CTL    = 8'h2F;
  localparam byte_t MK_UART       = 8'h9F;
  localparam byte_t MK_UART_CTL   = 8'h1F;
  localparam byte_t MK_IDE        = 8'h07;
  localparam byte_t MK_STRAP_KEEP = 8'h78;
  localparam byte_t MK_STRAP_WR   = 8'h01;

  // reset contents
  localparam byte_t RV_ID       = 8'hA0;
  localparam byte_t RV_FDC      = 8'h01;
  localparam byte_t RV_UART_CTL = 8'h02;
  localparam byte_t RV_IDE      = 8'h01;

  localparam int RST_BIT = 2;

  function automatic byte_t uart_ix(input int n);
    return byte_t'(int'(IX_UART_BASE) + int'(IX_UART_STEP) * n);
  endfunction

  function automatic port_t win_base_f(input logic [1:0] sel);
    case (sel)
      2'd0:    return port_t'(16'h0022);
      2'd1:    return port_t'(16'h0024);
      2'd2:    return port_t'(16'h026E);
      default: return port_t'(16'h0398);
    endcase
  endfunction

  function automatic port_t lpt_base_f(input logic [1:0] sel);
    case (sel)
      2'd0:    return port_t'(16'h0378);
      2'd1:    return port_t'(16'h0278);
      2'd2:    return port_t'(16'h03BC);
      default: return port_t'(16'h0000);
    endcase
  endfunction

  function automatic port_t uart_base_f(input logic [2:0] sel);
    case (sel)
      3'd0:    return port_t'(16'h03F8);
      3'd1:    return port_t'(16'h02F8);
      3'd2:    return port_t'(16'h0220);
      3'd3:    return port_t'(16'h0228);
      3'd4:    return port_t'(16'h0238);
      3'd5:    return port_t'(16'h02E8);
      3'd6:    return port_t'(16'h0338);
      default: return port_t'(16'h03E8);
    endcase
  endfunction
endpackage

// File: rtl/sio_cfg_window.sv
module sio_cfg_window
  import sio_cfg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    win_sel,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic [DW-1:0] idx,
  output logic          data_wr,
  input  logic [DW-1:0] reg_rd_val
);
  localparam logic [DW-1:0] IDLE_VAL = '1;

  logic [AW-1:0] base_a;
  logic          hit;
  logic          idx_wr;
  logic [DW-1:0] idx_q;

  assign base_a  = AW'(win_base_f(win_sel));
  assign hit     = (io_addr[AW-1:1] == base_a[AW-1:1]);
  assign idx_wr  = io_wr & hit & ~io_addr[0];
  assign data_wr = io_wr & hit & io_addr[0];
  assign idx     = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_wr) begin
      idx_q <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = IDLE_VAL;
    if (io_rd && hit) begin
      if (!io_addr[0]) begin
        io_rdata = idx_q;
      end else if (idx_q < DW'(IX_LIMIT)) begin
        io_rdata = reg_rd_val;
      end
    end
  end

  // R1: an index write stores the written byte
  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx_q == $past(io_wdata)));

  // R1: without an index write the index holds
  a_r1_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(idx_q));
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int UC = UART_CNT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW-1:0]         strap_id,
  input  logic                  wr_en,
  input  logic [DW-1:0]         idx,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rd_val,
  output logic [DW-1:0]         fdc_cfg,
  output logic [DW-1:0]         lpt_cfg,
  output logic [UC-1:0][DW-1:0] uart_cfg,
  output logic [DW-1:0]         ide_cfg,
  output logic                  fdc_rst,
  output logic [UC-1:0]         uart_rst,
  output logic                  fdc_chg,
  output logic                  lpt_chg,
  output logic [UC-1:0]         uart_chg,
  output logic                  ide_chg_raw
);
  // state
  logic                  strap_done;
  logic [DW-1:0]         r_strap, r_misc, r_fdc, r_fdc_ctl, r_lpt, r_lpt_ctl, r_ide;
  logic [UC-1:0][DW-1:0] r_uart, r_uctl;
  logic                  fdc_rst_q, fdc_chg_q, lpt_chg_q, ide_chg_q;
  logic [UC-1:0]         uart_rst_q, uart_chg_q;

  // next state
  logic [DW-1:0]         strap_nx, misc_nx, fdc_nx, fdc_ctl_nx, lpt_nx, lpt_ctl_nx, ide_nx;
  logic [UC-1:0][DW-1:0] uart_nx, uctl_nx;
  logic                  fdc_rst_nx, fdc_chg_nx, lpt_chg_nx, ide_chg_nx;
  logic [UC-1:0]         uart_rst_nx, uart_chg_nx;
  logic                  idx_known;

  always_comb begin
    strap_nx    = r_strap;
    misc_nx     = r_misc;
    fdc_nx      = r_fdc;
    fdc_ctl_nx  = r_fdc_ctl;
    lpt_nx      = r_lpt;
    lpt_ctl_nx  = r_lpt_ctl;
    ide_nx      = r_ide;
    uart_nx     = r_uart;
    uctl_nx     = r_uctl;
    fdc_rst_nx  = 1'b0;
    uart_rst_nx = '0;
    if (!strap_done) begin
      strap_nx = strap_id;
    end else if (wr_en) begin
      case (idx)
        DW'(IX_STRAP):   strap_nx   = (r_strap & DW'(MK_STRAP_KEEP)) | (wdata & DW'(MK_STRAP_WR));
        DW'(IX_MISC):    misc_nx    = wdata & DW'(MK_MISC);
        DW'(IX_FDC):     fdc_nx     = wdata & DW'(MK_FDC);
        DW'(IX_FDC_CTL): begin
          fdc_ctl_nx = wdata & DW'(MK_FDC_CTL);
          fdc_rst_nx = wdata[RST_BIT] & ~r_fdc_ctl[RST_BIT];
        end
        DW'(IX_LPT):     lpt_nx     = wdata & DW'(MK_LPT);
        DW'(IX_LPT_CTL): lpt_ctl_nx = wdata & DW'(MK_LPT_CTL);
        DW'(IX_IDE):     ide_nx     = wdata & DW'(MK_IDE);
        default: ;
      endcase
      for (int i = 0; i < UC; i++) begin
        if (idx == DW'(uart_ix(i))) begin
          uart_nx[i] = wdata & DW'(MK_UART);
        end
        if (idx == DW'(uart_ix(i) + IX_CTL_OFS)) begin
          uctl_nx[i]     = wdata & DW'(MK_UART_CTL);
          uart_rst_nx[i] = wdata[RST_BIT] & ~r_uctl[i][RST_BIT];
        end
      end
    end
  end

  // change detection on the decode-relevant fields
  always_comb begin
    fdc_chg_nx = (fdc_nx[1:0] != r_fdc[1:0]);
    lpt_chg_nx = (lpt_nx[2:0] != r_lpt[2:0]);
    ide_chg_nx = (ide_nx[1:0] != r_ide[1:0]);
    for (int i = 0; i < UC; i++) begin
      uart_chg_nx[i] = (uart_nx[i][3:1] != r_uart[i][3:1]);
    end
  end

  // read mux
  always_comb begin
    case (idx)
      DW'(IX_ID):      rd_val = DW'(RV_ID);
      DW'(IX_STRAP):   rd_val = r_strap;
      DW'(IX_MISC):    rd_val = r_misc;
      DW'(IX_FDC):     rd_val = r_fdc;
      DW'(IX_FDC_CTL): rd_val = r_fdc_ctl;
      DW'(IX_LPT):     rd_val = r_lpt;
      DW'(IX_LPT_CTL): rd_val = r_lpt_ctl;
      DW'(IX_IDE):     rd_val = r_ide;
      default:         rd_val = '0;
    endcase
    for (int i = 0; i < UC; i++) begin
      if (idx == DW'(uart_ix(i)))              rd_val = r_uart[i];
      if (idx == DW'(uart_ix(i) + IX_CTL_OFS)) rd_val = r_uctl[i];
    end
  end

  // known-index flag, kept apart from the write decode for checking
  always_comb begin
    idx_known = (idx == DW'(IX_STRAP)) || (idx == DW'(IX_MISC)) ||
                (idx == DW'(IX_FDC)) || (idx == DW'(IX_FDC_CTL)) ||
                (idx == DW'(IX_LPT)) || (idx == DW'(IX_LPT_CTL)) ||
                (idx == DW'(IX_IDE));
    for (int i = 0; i < UC; i++) begin
      if ((idx == DW'(uart_ix(i))) || (idx == DW'(uart_ix(i) + IX_CTL_OFS))) begin
        idx_known = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_done <= 1'b0;
      r_strap    <= '0;
      r_misc     <= '0;
      r_fdc      <= DW'(RV_FDC);
      r_fdc_ctl  <= '0;
      r_lpt      <= '0;
      r_lpt_ctl  <= '0;
      r_ide      <= DW'(RV_IDE);
      r_uart     <= '0;
      r_uctl     <= {UC{DW'(RV_UART_CTL)}};
      fdc_rst_q  <= 1'b0;
      uart_rst_q <= '0;
      fdc_chg_q  <= 1'b0;
      lpt_chg_q  <= 1'b0;
      uart_chg_q <= '0;
      ide_chg_q  <= 1'b0;
    end else begin
      strap_done <= 1'b1;
      r_strap    <= strap_nx;
      r_misc     <= misc_nx;
      r_fdc      <= fdc_nx;
      r_fdc_ctl  <= fdc_ctl_nx;
      r_lpt      <= lpt_nx;
      r_lpt_ctl  <= lpt_ctl_nx;
      r_ide      <= ide_nx;
      r_uart     <= uart_nx;
      r_uctl     <= uctl_nx;
      fdc_rst_q  <= fdc_rst_nx;
      uart_rst_q <= uart_rst_nx;
      fdc_chg_q  <= fdc_chg_nx;
      lpt_chg_q  <= lpt_chg_nx;
      uart_chg_q <= uart_chg_nx;
      ide_chg_q  <= ide_chg_nx;
    end
  end

  assign fdc_cfg     = r_fdc;
  assign lpt_cfg     = r_lpt;
  assign uart_cfg    = r_uart;
  assign ide_cfg     = r_ide;
  assign fdc_rst     = fdc_rst_q;
  assign uart_rst    = uart_rst_q;
  assign fdc_chg     = fdc_chg_q;
  assign lpt_chg     = lpt_chg_q;
  assign uart_chg    = uart_chg_q;
  assign ide_chg_raw = ide_chg_q;

  // R3: writes to unlisted indices leave all state unchanged
  a_r3_unlisted_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && strap_done && !idx_known) |=>
      $stable({r_strap, r_misc, r_fdc, r_fdc_ctl, r_lpt, r_lpt_ctl, r_ide, r_uart, r_uctl}));

  // R4: strap bits 6:3 never move after the load
  a_r4_strap_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> (r_strap[6:3] == $past(r_strap[6:3])));

  // R9: floppy reset pulse is one cycle, on a 0->1 edge of the reset bit
  a_r9_fdc_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_rst |=> !fdc_rst);
  a_r9_fdc_pulse_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_rst |-> (r_fdc_ctl[RST_BIT] && !$past(r_fdc_ctl[RST_BIT])));

  // R11: floppy strobe matches a change of its decode bits
  a_r11_fdc_chg_match: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_chg == (r_fdc[1:0] != $past(r_fdc[1:0])));
  a_r11_lpt_chg_match: assert property (@(posedge clk) disable iff (!rst_n)
    lpt_chg == (r_lpt[2:0] != $past(r_lpt[2:0])));

  for (genvar g = 0; g < UC; g++) begin : g_uart_chk
    // R9: serial reset pulse on a 0->1 edge only
    a_r9_uart_pulse_edge: assert property (@(posedge clk) disable iff (!rst_n)
      uart_rst[g] |-> (r_uctl[g][RST_BIT] && !$past(r_uctl[g][RST_BIT])));
    // R11: serial strobe matches a change of its base select
    a_r11_uart_chg_match: assert property (@(posedge clk) disable iff (!rst_n)
      uart_chg[g] == (r_uart[g][3:1] != $past(r_uart[g][3:1])));
  end
endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PORT_W,
  parameter int IW = IRQ_W,
  parameter int UC = UART_CNT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW-1:0]         fdc_cfg,
  input  logic [DW-1:0]         lpt_cfg,
  input  logic [UC-1:0][DW-1:0] uart_cfg,
  input  logic [DW-1:0]         ide_cfg,
  input  logic                  ide_present,
  input  logic                  ide_chg_raw,
  output logic                  fdc_en,
  output logic [PW-1:0]         fdc_base,
  output logic                  lpt_en,
  output logic [PW-1:0]         lpt_base,
  output logic [IW-1:0]         lpt_irq,
  output logic [UC*PW-1:0]      uart_base,
  output logic [UC*IW-1:0]      uart_irq,
  output logic [UC-1:0]         uart_clk_2m,
  output logic                  ide_en,
  output logic [PW-1:0]         ide_cmd_base,
  output logic [PW-1:0]         ide_ctl_base,
  output logic                  ide_chg
);
  localparam logic [PW-1:0] FDC_PRI = PW'(16'h03F0);
  localparam logic [PW-1:0] FDC_SEC = PW'(16'h0370);
  localparam logic [PW-1:0] IDE_CMD_PRI = PW'(16'h01F0);
  localparam logic [PW-1:0] IDE_CMD_SEC = PW'(16'h0170);
  localparam logic [PW-1:0] IDE_CTL_PRI = PW'(16'h03F6);
  localparam logic [PW-1:0] IDE_CTL_SEC = PW'(16'h0376);
  localparam logic [1:0]    LPT_OFF = 2'd3;

  logic [1:0] lpt_sel;

  assign fdc_en   = fdc_cfg[0];
  assign fdc_base = fdc_cfg[1] ? FDC_SEC : FDC_PRI;

  assign lpt_sel  = lpt_cfg[2:1];
  assign lpt_base = PW'(lpt_base_f(lpt_sel));
  assign lpt_en   = lpt_cfg[0] && (lpt_sel != LPT_OFF);
  assign lpt_irq  = lpt_cfg[3] ? IW'(7) : IW'(5);

  for (genvar g = 0; g < UC; g++) begin : g_uart
    assign uart_base[g*PW +: PW] = PW'(uart_base_f(uart_cfg[g][3:1]));
    assign uart_irq[g*IW +: IW]  = uart_cfg[g][4] ? IW'(4) : IW'(3);
    assign uart_clk_2m[g]        = uart_cfg[g][7];
  end

  always_comb begin
    ide_en       = 1'b0;
    ide_cmd_base = '0;
    ide_ctl_base = '0;
    ide_chg      = 1'b0;
    if (ide_present) begin
      ide_en       = ide_cfg[0];
      ide_cmd_base = ide_cfg[1] ? IDE_CMD_SEC : IDE_CMD_PRI;
      ide_ctl_base = ide_cfg[1] ? IDE_CTL_SEC : IDE_CTL_PRI;
      ide_chg      = ide_chg_raw;
    end
  end

  // R7: an enabled parallel port always has a real base
  a_r7_lpt_en_base: assert property (@(posedge clk) disable iff (!rst_n)
    lpt_en |-> (lpt_base != '0));

  // R10: without the strap the IDE outputs stay quiet
  a_r10_ide_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_present |-> (!ide_en && (ide_cmd_base == '0) && (ide_ctl_base == '0) && !ide_chg));
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int PW = PORT_W,
  parameter int IW = IRQ_W,
  parameter int UC = UART_CNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap_win_sel,
  input  logic [DW-1:0]    strap_id,
  input  logic             strap_ide_present,
  input  logic [AW-1:0]    io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  output logic             fdc_en,
  output logic [PW-1:0]    fdc_base,
  output logic             fdc_reset_pulse,
  output logic             fdc_cfg_change,
  output logic             lpt_en,
  output logic [PW-1:0]    lpt_base,
  output logic [IW-1:0]    lpt_irq,
  output logic             lpt_cfg_change,
  output logic [UC*PW-1:0] uart_base,
  output logic [UC*IW-1:0] uart_irq,
  output logic [UC-1:0]    uart_clk_2m,
  output logic [UC-1:0]    uart_reset_pulse,
  output logic [UC-1:0]    uart_cfg_change,
  output logic             ide_en,
  output logic [PW-1:0]    ide_cmd_base,
  output logic [PW-1:0]    ide_ctl_base,
  output logic             ide_cfg_change
);
  // reset: asserted asynchronously, released after two clocks
  logic rst_meta, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  logic [DW-1:0]         idx, reg_rd_val, fdc_cfg, lpt_cfg, ide_cfg;
  logic [UC-1:0][DW-1:0] uart_cfg;
  logic                  data_wr, ide_chg_raw;

  sio_cfg_window #(.AW(AW), .DW(DW)) u_window (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .win_sel    (strap_win_sel),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .idx        (idx),
    .data_wr    (data_wr),
    .reg_rd_val (reg_rd_val)
  );

  sio_cfg_regs #(.DW(DW), .UC(UC)) u_regs (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .strap_id    (strap_id),
    .wr_en       (data_wr),
    .idx         (idx),
    .wdata       (io_wdata),
    .rd_val      (reg_rd_val),
    .fdc_cfg     (fdc_cfg),
    .lpt_cfg     (lpt_cfg),
    .uart_cfg    (uart_cfg),
    .ide_cfg     (ide_cfg),
    .fdc_rst     (fdc_reset_pulse),
    .uart_rst    (uart_reset_pulse),
    .fdc_chg     (fdc_cfg_change),
    .lpt_chg     (lpt_cfg_change),
    .uart_chg    (uart_cfg_change),
    .ide_chg_raw (ide_chg_raw)
  );

  sio_cfg_decode #(.DW(DW), .PW(PW), .IW(IW), .UC(UC)) u_decode (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .fdc_cfg      (fdc_cfg),
    .lpt_cfg      (lpt_cfg),
    .uart_cfg     (uart_cfg),
    .ide_cfg      (ide_cfg),
    .ide_present  (strap_ide_present),
    .ide_chg_raw  (ide_chg_raw),
    .fdc_en       (fdc_en),
    .fdc_base     (fdc_base),
    .lpt_en       (lpt_en),
    .lpt_base     (lpt_base),
    .lpt_irq      (lpt_irq),
    .uart_base    (uart_base),
    .uart_irq     (uart_irq),
    .uart_clk_2m  (uart_clk_2m),
    .ide_en       (ide_en),
    .ide_cmd_base (ide_cmd_base),
    .ide_ctl_base (ide_ctl_base),
    .ide_chg      (ide_cfg_change)
  );

  // R12: a reset pulse and the new register contents appear together
  a_r12_fdc_pulse_data: assert property (@(posedge clk) disable iff (!rst_core_n)
    fdc_reset_pulse |-> $past(data_wr));
endmodule

// File: tb/sio_cfg_regfile_bench.sv
module sio_cfg_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  strap_win_sel;
  logic [7:0]  strap_id;
  logic        strap_ide_present;
  logic [15:0] io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata;
  logic        fdc_en, fdc_reset_pulse, fdc_cfg_change;
  logic [15:0] fdc_base, lpt_base, ide_cmd_base, ide_ctl_base;
  logic        lpt_en, lpt_cfg_change, ide_en, ide_cfg_change;
  logic [3:0]  lpt_irq;
  logic [31:0] uart_base;
  logic [7:0]  uart_irq;
  logic [1:0]  uart_clk_2m, uart_reset_pulse, uart_cfg_change;

  int checks = 0;
  int failures = 0;
  logic [15:0] wb;
  logic [7:0]  d;

  always #10 clk = ~clk;

  sio_cfg_regfile u_sio_cfg_regfile (.*);

  // {index, write data, expected read-back}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    24'h03_FF_F8, 24'h10_FF_83, 24'h11_FF_0F, 24'h20_FF_EF,
    24'h21_FF_2F, 24'h30_FF_9F, 24'h40_6A_0A, 24'h31_FF_1F,
    24'h41_E0_00, 24'h50_FF_07, 24'h00_55_A0, 24'h12_FF_00,
    24'h60_12_FF
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] win_of(input logic [1:0] s);
    case (s)
      2'd0: return 16'h0022;
      2'd1: return 16'h0024;
      2'd2: return 16'h026E;
      default: return 16'h0398;
    endcase
  endfunction

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_wdata = v; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 v = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] v);
    bus_wr(wb, ix);
    bus_wr(wb + 16'd1, v);
  endtask

  task automatic reg_rd(input logic [7:0] ix, output logic [7:0] v);
    bus_wr(wb, ix);
    bus_rd(wb + 16'd1, v);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    io_addr = '0; io_wr = 0; io_rd = 0; io_wdata = '0;
    strap_win_sel = 2'd0; strap_id = 8'hC5; strap_ide_present = 1'b1;
    wb = win_of(2'd0);
    do_reset();

    // reset state (R5, R4, R6-R10)
    chk("R2 idle read", {24'h0, io_rdata}, 32'hFF);
    reg_rd(8'h00, d); chk("R5 reg00", d, 32'hA0);
    reg_rd(8'h10, d); chk("R5 reg10", d, 32'h01);
    reg_rd(8'h31, d); chk("R5 reg31", d, 32'h02);
    reg_rd(8'h41, d); chk("R5 reg41", d, 32'h02);
    reg_rd(8'h50, d); chk("R5 reg50", d, 32'h01);
    reg_rd(8'h20, d); chk("R5 reg20", d, 32'h00);
    reg_rd(8'h02, d); chk("R4 strap load", d, 32'hC5);
    bus_rd(wb, d);    chk("R2 index read", d, 32'h02);
    chk("R6 reset fdc_en", fdc_en, 1);
    chk("R6 reset fdc_base", fdc_base, 32'h03F0);
    chk("R7 reset lpt", {lpt_en, lpt_irq, lpt_base}, {1'b0, 4'd5, 16'h0378});
    chk("R8 reset uart_base", uart_base, 32'h03F8_03F8);
    chk("R8 reset uart_irq/clk", {uart_irq, uart_clk_2m}, {8'h33, 2'b00});
    chk("R10 reset ide", {ide_en, ide_cmd_base, ide_ctl_base}, {1'b1, 16'h01F0, 16'h03F6});
    chk("R9 reset pulses", {fdc_reset_pulse, uart_reset_pulse}, 0);

    // mask table (R3; last entries also R2, R5)
    for (int i = 0; i < NV; i++) begin
      reg_wr(VEC[i][23:16], VEC[i][15:8]);
      reg_rd(VEC[i][23:16], d);
      chk($sformatf("R3 mask idx %0h", VEC[i][23:16]), d, VEC[i][7:0]);
    end

    // decodes after the table
    chk("R6 fdc alt base", {fdc_en, fdc_base}, {1'b1, 16'h0370});
    chk("R7 lpt sel3 off", {lpt_en, lpt_irq, lpt_base}, {1'b0, 4'd7, 16'h0000});
    chk("R8 uart bases", uart_base, {16'h02E8, 16'h03E8});
    chk("R8 uart irq", uart_irq, {4'd3, 4'd4});
    chk("R8 uart clk", uart_clk_2m, 2'b01);
    chk("R10 ide alt", {ide_en, ide_cmd_base, ide_ctl_base}, {1'b1, 16'h0170, 16'h0376});

    // reset pulses R9
    reg_wr(8'h11, 8'h00);
    reg_wr(8'h11, 8'h04);
    chk("R9 fdc pulse high", fdc_reset_pulse, 1);
    @(negedge clk);
    chk("R9 fdc pulse one cycle", fdc_reset_pulse, 0);
    reg_wr(8'h11, 8'h04);
    chk("R9 no pulse when already set", fdc_reset_pulse, 0);
    reg_wr(8'h41, 8'h04);
    chk("R9 uart1 pulse", uart_reset_pulse, 2'b10);
    @(negedge clk);
    chk("R9 uart1 pulse one cycle", uart_reset_pulse, 2'b00);

    // change strobes R11 / timing R12
    reg_wr(8'h10, 8'h81);
    chk("R11 fdc change", fdc_cfg_change, 1);
    chk("R12 fdc base with strobe", fdc_base, 32'h03F0);
    @(negedge clk);
    chk("R11 fdc change one cycle", fdc_cfg_change, 0);
    reg_wr(8'h10, 8'h01);
    chk("R11 no fdc change on bit7", fdc_cfg_change, 0);
    reg_wr(8'h20, 8'h09);
    chk("R11 lpt change", lpt_cfg_change, 1);
    chk("R7 lpt 378 irq7", {lpt_en, lpt_irq, lpt_base}, {1'b1, 4'd7, 16'h0378});
    reg_wr(8'h20, 8'h03);
    chk("R7 lpt 278 irq5", {lpt_en, lpt_irq, lpt_base}, {1'b1, 4'd5, 16'h0278});
    reg_wr(8'h20, 8'h05);
    chk("R7 lpt 3BC", lpt_base, 32'h03BC);
    reg_wr(8'h30, 8'h04);
    chk("R11 uart0 change", uart_cfg_change, 2'b01);
    chk("R8 uart0 220", uart_base[15:0], 32'h0220);
    reg_wr(8'h30, 8'h14);
    chk("R11 no uart change on irq bit", uart_cfg_change, 2'b00);
    chk("R8 uart0 irq4", uart_irq[3:0], 4);

    // window placement R1
    strap_win_sel = 2'd2; wb = win_of(2'd2);
    bus_wr(wb, 8'h21);
    bus_rd(wb, d); chk("R1 index at 0x26E", d, 32'h21);
    bus_rd(16'h0023, d); chk("R1 old window dead", d, 32'hFF);
    bus_wr(16'h0022, 8'h50);
    bus_rd(wb, d); chk("R1 foreign write ignored", d, 32'h21);
    bus_rd(wb + 16'd1, d); chk("R1 data at 0x26F", d, 32'h2F);
    strap_win_sel = 2'd1; wb = win_of(2'd1);
    reg_rd(8'h03, d); chk("R1 window 0x24", d, 32'hF8);
    strap_win_sel = 2'd3; wb = win_of(2'd3);

    // strap register R4
    reg_wr(8'h02, 8'h00);
    reg_rd(8'h02, d); chk("R4 strap write clear b0", d, 32'h40);
    reg_wr(8'h02, 8'hFF);
    reg_rd(8'h02, d); chk("R4 strap write set b0", d, 32'h41);

    // IDE strap absent R10
    strap_ide_present = 1'b0;
    reg_wr(8'h50, 8'h05);
    chk("R10 ide gated", {ide_en, ide_cmd_base, ide_ctl_base, ide_cfg_change}, 0);
    strap_ide_present = 1'b1;
    #1 chk("R10 ide ungated", {ide_en, ide_cmd_base}, {1'b1, 16'h01F0});

    // second reset with a new strap R5 / R4
    strap_id = 8'h3C;
    do_reset();
    reg_rd(8'h02, d); chk("R4 new strap", d, 32'h3C);
    reg_rd(8'h10, d); chk("R5 reg10 after reset", d, 32'h01);
    reg_rd(8'h30, d); chk("R5 reg30 after reset", d, 32'h00);
    chk("R8 clk after reset", uart_clk_2m, 2'b00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule